// File: doc/BRIEF.md
# Audio Control Settings Receiver (Two-Wire Serial, Write-Only)

This block lets a host processor set up an audio processor over a two-wire serial bus that uses I2C framing. It only ever receives. SCL and SDA come in as plain inputs sampled by the system clock, and the block pulls SDA low through an open-drain enable whenever it acknowledges. One strap input picks which of two bus addresses the block answers to.

A write transfer has a fixed shape. A START comes first, then the address byte with the write bit, then a subaddress byte, then any number of data bytes. Each data byte lands in the register that the current subaddress points to, and the subaddress then advances by one. The register map has a gap between 0x04 and 0x08. A burst that runs through the gap still gets every byte acknowledged, but the bytes in the gap are thrown away.

All stored settings are driven out in parallel on separate ports:

- master volume, left trim and right trim
- bass and treble
- two source selectors
- two mute flags
- two effect flags and a stereo flag
- two general-purpose port pins

Reset leaves both mute flags set and every other field at zero.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 1000000 while addr_sel_i is 0, or equal 1000001 while addr_sel_i is 1, and whose LSB (the read/write bit) is 0. To acknowledge, it holds sda_oe_o high for exactly the ninth SCL clock of that byte.
- R2: After an address byte with the wrong address, or with the LSB set to 1, the block leaves SDA released. It then acknowledges nothing and changes no register until the next START.
- R3: Once the address is accepted, the block acknowledges the subaddress byte and every data byte that follows. A setting output changes only as the result of a stored data byte.
- R4: Every data byte after the first goes to the subaddress one above the previous byte's subaddress. The count does not return to 0 after 0x09.
- R5: The fields are taken from the low bits of the data byte:
  - 0x00 bits 5..0 become vol_main_o.
  - 0x01 bits 4..0 become vol_left_o.
  - 0x02 bits 4..0 become vol_right_o.
  - 0x03 bits 4..0 become bass_o.
  - 0x04 bits 3..0 become treble_o.
- R6: A byte written to 0x08 is split as follows, and its bit 7 is ignored:
  - bit 6 becomes sec_mute_o
  - bit 5 becomes port_a_o
  - bit 4 becomes port_b_o
  - bits 3..0 become sec_src_o
- R7: A byte written to 0x09 is split as follows:
  - bit 7 becomes fx_hi_o
  - bit 6 becomes spk_mute_o
  - bit 5 becomes fx_lo_o
  - bit 4 becomes stereo_o
  - bits 3..0 become spk_src_o
- R8: Bytes sent to subaddresses 0x05 to 0x07, or to any subaddress above 0x09, are acknowledged but change no output. A burst that starts at 0x04 reaches 0x08 with its fifth data byte.
- R9: After reset, sec_mute_o and spk_mute_o are 1 and every other output is 0. A mute flag stays 1 until a data byte writes it to 0.
- R10: A repeated START (with no STOP before it) makes the block expect a fresh address byte, and a new transfer then proceeds normally.
- R11: Outside the acknowledge clocks the block never pulls SDA low. It releases SDA on the SCL falling edge that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, which samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Address strap that chooses the address LSB |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| vol_main_o | output | 6 | Master volume code |
| vol_left_o | output | 5 | Left trim code |
| vol_right_o | output | 5 | Right trim code |
| bass_o | output | 5 | Bass code |
| treble_o | output | 4 | Treble code |
| sec_src_o | output | 4 | Source selection for the secondary output |
| sec_mute_o | output | 1 | Mute for the secondary output |
| port_a_o | output | 1 | General-purpose port A level |
| port_b_o | output | 1 | General-purpose port B level |
| spk_src_o | output | 4 | Source selection for the loudspeaker path |
| spk_mute_o | output | 1 | Mute for the loudspeaker path |
| fx_hi_o | output | 1 | Effect flag taken from bit 7 of 0x09 |
| fx_lo_o | output | 1 | Effect flag taken from bit 5 of 0x09 |
| stereo_o | output | 1 | Stereo flag |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and a base address of 1000000. Its SCL quarter-period is six system clocks, which is longer than the synchroniser and edge-detect latency, so the acknowledge is driven and released well inside the SCL low phase. Because addr_sel_i is toggled between transfers, both bus addresses are exercised under the same build. Random bursts start at subaddresses from 0x00 to 0x0B, which sends writes through the gap in the map and past its top end.

// File: rtl/actl_pkg.sv
package actl_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned VOLM_W = 6;
  localparam int unsigned TRIM_W = 5;
  localparam int unsigned BASS_W = 5;
  localparam int unsigned TREB_W = 4;
  localparam int unsigned SRC_W  = 4;

  localparam logic [BYTE_W-1:0] SA_VOLM  = 8'h00;
  localparam logic [BYTE_W-1:0] SA_LEFT  = 8'h01;
  localparam logic [BYTE_W-1:0] SA_RIGHT = 8'h02;
  localparam logic [BYTE_W-1:0] SA_BASS  = 8'h03;
  localparam logic [BYTE_W-1:0] SA_TREB  = 8'h04;
  localparam logic [BYTE_W-1:0] SA_SEC   = 8'h08;
  localparam logic [BYTE_W-1:0] SA_SPK   = 8'h09;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_ACK, ST_SKIP} eng_state_e;
  typedef enum logic [1:0] {PH_ADDR, PH_SUB, PH_DATA} eng_phase_e;

  typedef struct packed {
    logic [VOLM_W-1:0] vol_main;
    logic [TRIM_W-1:0] vol_left;
    logic [TRIM_W-1:0] vol_right;
    logic [BASS_W-1:0] bass;
    logic [TREB_W-1:0] treble;
    logic [SRC_W-1:0]  sec_src;
    logic              sec_mute;
    logic              port_a;
    logic              port_b;
    logic [SRC_W-1:0]  spk_src;
    logic              spk_mute;
    logic              fx_hi;
    logic              fx_lo;
    logic              stereo;
  } ctl_regs_t;

  localparam ctl_regs_t REGS_RST = '{sec_mute: 1'b1, spk_mute: 1'b1, default: '0};
endpackage

// File: rtl/actl_bus_sync.sv
module actl_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_s, sda_s, scl_d, sda_d;

  if (STAGES <= 1) begin : g_single
    logic scl_r, sda_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_r <= 1'b1;
        sda_r <= 1'b1;
      end else begin
        scl_r <= scl_i;
        sda_r <= sda_i;
      end
    end
    assign scl_s = scl_r;
    assign sda_s = sda_r;
  end else begin : g_chain
    logic [STAGES-1:0] scl_r, sda_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_r <= '1;
        sda_r <= '1;
      end else begin
        scl_r <= {scl_r[STAGES-2:0], scl_i};
        sda_r <= {sda_r[STAGES-2:0], sda_i};
      end
    end
    assign scl_s = scl_r[STAGES-1];
    assign sda_s = sda_r[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // data edges while clock stays high frame a transfer
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/actl_byte_engine.sv
module actl_byte_engine
  import actl_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'b1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_sel_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              skip_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  eng_state_e        state_q;
  eng_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q, ptr_q, wdata_q;
  logic              oe_q, wr_q;
  logic [6:0]        dev_addr;
  logic              addr_ok;

  assign dev_addr = BASE_ADDR | {6'd0, addr_sel_i};
  assign addr_ok  = (shreg_q[BYTE_W-1:1] == dev_addr) && !shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      shreg_q <= '0;
      ptr_q   <= '0;
      wdata_q <= '0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_RECV;
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RECV: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              unique case (phase_q)
                PH_ADDR: begin
                  if (addr_ok) begin
                    state_q <= ST_ACK;
                    oe_q    <= 1'b1;
                  end else begin
                    state_q <= ST_SKIP;
                  end
                end
                PH_SUB: begin
                  ptr_q   <= shreg_q;
                  state_q <= ST_ACK;
                  oe_q    <= 1'b1;
                end
                default: begin
                  wr_q    <= 1'b1;
                  wdata_q <= shreg_q;
                  state_q <= ST_ACK;
                  oe_q    <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              state_q <= ST_RECV;
              unique case (phase_q)
                PH_ADDR: phase_q <= PH_SUB;
                PH_SUB:  phase_q <= PH_DATA;
                default: ptr_q   <= ptr_q + 1'b1;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_q;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = wdata_q;
  assign skip_o    = (state_q == ST_SKIP);
endmodule

// File: rtl/actl_reg_file.sv
module actl_reg_file
  import actl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output ctl_regs_t         regs_o
);
  ctl_regs_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= REGS_RST;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        SA_VOLM:  regs_q.vol_main  <= wr_data_i[VOLM_W-1:0];
        SA_LEFT:  regs_q.vol_left  <= wr_data_i[TRIM_W-1:0];
        SA_RIGHT: regs_q.vol_right <= wr_data_i[TRIM_W-1:0];
        SA_BASS:  regs_q.bass      <= wr_data_i[BASS_W-1:0];
        SA_TREB:  regs_q.treble    <= wr_data_i[TREB_W-1:0];
        SA_SEC: begin
          regs_q.sec_mute <= wr_data_i[6];
          regs_q.port_a   <= wr_data_i[5];
          regs_q.port_b   <= wr_data_i[4];
          regs_q.sec_src  <= wr_data_i[SRC_W-1:0];
        end
        SA_SPK: begin
          regs_q.fx_hi    <= wr_data_i[7];
          regs_q.spk_mute <= wr_data_i[6];
          regs_q.fx_lo    <= wr_data_i[5];
          regs_q.stereo   <= wr_data_i[4];
          regs_q.spk_src  <= wr_data_i[SRC_W-1:0];
        end
        default: ; // unmapped: acknowledged, dropped
      endcase
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import actl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  BASE_ADDR   = 7'b1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic [VOLM_W-1:0] vol_main_o,
  output logic [TRIM_W-1:0] vol_left_o,
  output logic [TRIM_W-1:0] vol_right_o,
  output logic [BASS_W-1:0] bass_o,
  output logic [TREB_W-1:0] treble_o,
  output logic [SRC_W-1:0]  sec_src_o,
  output logic              sec_mute_o,
  output logic              port_a_o,
  output logic              port_b_o,
  output logic [SRC_W-1:0]  spk_src_o,
  output logic              spk_mute_o,
  output logic              fx_hi_o,
  output logic              fx_lo_o,
  output logic              stereo_o
);
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              wr_en, ignoring;
  logic [BYTE_W-1:0] wr_addr, wr_data;
  ctl_regs_t         regs;

  actl_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  actl_byte_engine #(.BASE_ADDR(BASE_ADDR)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_sel_i (addr_sel_i),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .skip_o     (ignoring)
  );

  actl_reg_file u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .regs_o    (regs)
  );

  assign vol_main_o  = regs.vol_main;
  assign vol_left_o  = regs.vol_left;
  assign vol_right_o = regs.vol_right;
  assign bass_o      = regs.bass;
  assign treble_o    = regs.treble;
  assign sec_src_o   = regs.sec_src;
  assign sec_mute_o  = regs.sec_mute;
  assign port_a_o    = regs.port_a;
  assign port_b_o    = regs.port_b;
  assign spk_src_o   = regs.spk_src;
  assign spk_mute_o  = regs.spk_mute;
  assign fx_hi_o     = regs.fx_hi;
  assign fx_lo_o     = regs.fx_lo;
  assign stereo_o    = regs.stereo;
endmodule

// File: rtl/audio_ctl_i2c_slave_chk.sv
module audio_ctl_i2c_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic        ignoring,
  input logic [39:0] cfg_flat
);
  // R3
  no_stray_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(cfg_flat));

  // R8
  hole_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && ((wr_addr >= 8'h05 && wr_addr <= 8'h07) || wr_addr > 8'h09)) |=> $stable(cfg_flat));

  // R2
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignoring |-> (!sda_oe_o && !wr_en));

  // R11
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && scl_i) |=> sda_oe_o);

  // R1
  ack_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  // R3
  write_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> sda_oe_o);
endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .ignoring (ignoring),
  .cfg_flat ({vol_main_o, vol_left_o, vol_right_o, bass_o, treble_o,
              sec_src_o, sec_mute_o, port_a_o, port_b_o,
              spk_src_o, spk_mute_o, fx_hi_o, fx_lo_o, stereo_o})
);

// File: tb/audio_ctl_i2c_slave_tb.sv
module audio_ctl_i2c_slave_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sel = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [5:0] vol_main;
  logic [4:0] vol_left, vol_right, bass;
  logic [3:0] treble, sec_src, spk_src;
  logic sec_mute, port_a, port_b, spk_mute, fx_hi, fx_lo, stereo;

  int n_chk = 0, n_bad = 0, glitch = 0;
  bit done = 1'b0;
  logic [7:0] dbuf [8];

  // bench model
  logic [5:0] m_vm;
  logic [4:0] m_vl, m_vr, m_ba;
  logic [3:0] m_tr, m_ss, m_ks;
  logic m_sm, m_pa, m_pb, m_km, m_fh, m_fl, m_st;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  audio_ctl_i2c_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_bus), .addr_sel_i(sel),
    .sda_oe_o(sda_oe), .vol_main_o(vol_main), .vol_left_o(vol_left), .vol_right_o(vol_right),
    .bass_o(bass), .treble_o(treble), .sec_src_o(sec_src), .sec_mute_o(sec_mute),
    .port_a_o(port_a), .port_b_o(port_b), .spk_src_o(spk_src), .spk_mute_o(spk_mute),
    .fx_hi_o(fx_hi), .fx_lo_o(fx_lo), .stereo_o(stereo)
  );

  wire [39:0] dut_vec = {vol_main, vol_left, vol_right, bass, treble,
                         sec_src, sec_mute, port_a, port_b,
                         spk_src, spk_mute, fx_hi, fx_lo, stereo};

  function automatic logic [39:0] model_vec();
    return {m_vm, m_vl, m_vr, m_ba, m_tr, m_ss, m_sm, m_pa, m_pb, m_ks, m_km, m_fh, m_fl, m_st};
  endfunction

  function automatic int exp_acks(input logic [6:0] a, input logic rd, input int n);
    return (a == {6'b100000, sel} && !rd) ? 2 + n : 0;
  endfunction

  task automatic model_reset();
    {m_vm, m_vl, m_vr, m_ba, m_tr, m_ss, m_pa, m_pb, m_ks, m_fh, m_fl, m_st} = '0;
    m_sm = 1'b1;
    m_km = 1'b1;
  endtask

  task automatic model_write(input logic [7:0] p, input logic [7:0] d);
    case (p)
      8'h00: m_vm = d[5:0];
      8'h01: m_vl = d[4:0];
      8'h02: m_vr = d[4:0];
      8'h03: m_ba = d[4:0];
      8'h04: m_tr = d[3:0];
      8'h08: begin m_sm = d[6]; m_pa = d[5]; m_pb = d[4]; m_ss = d[3:0]; end
      8'h09: begin m_fh = d[7]; m_km = d[6]; m_fl = d[5]; m_st = d[4]; m_ks = d[3:0]; end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(Q); sda_m = 1'b1;
    tick(Q); scl = 1'b1;
    tick(Q); sda_m = 1'b0;
    tick(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0;
    tick(Q); scl = 1'b1;
    tick(Q); sda_m = 1'b1;
    tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output int ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = b[i];
      tick(Q); scl = 1'b1;
      tick(Q); if (sda_bus !== b[i]) glitch++;
      tick(Q); scl = 1'b0;
    end
    tick(Q); sda_m = 1'b1;
    tick(Q); scl = 1'b1;
    tick(Q); ack = (sda_bus === 1'b0) ? 1 : 0;
    tick(Q); scl = 1'b0;
  endtask

  task automatic xfer(input logic [6:0] a, input logic rd, input logic [7:0] sub,
                      input int n, input bit stop_end, output int acks);
    int ak;
    logic [7:0] p;
    acks = 0;
    bus_start();
    send_byte({a, rd}, ak); acks += ak;
    send_byte(sub, ak);     acks += ak;
    for (int i = 0; i < n; i++) begin
      send_byte(dbuf[i], ak); acks += ak;
    end
    if (stop_end) bus_stop();
    if (a == {6'b100000, sel} && !rd) begin
      p = sub;
      for (int i = 0; i < n; i++) begin
        model_write(p, dbuf[i]);
        p = p + 8'd1;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int acks;
    int seed;
    logic [7:0] sub;
    int n;
    logic [6:0] a;
    logic rd;
    seed = $urandom(32'd20240611);
    model_reset();
    tick(4);
    rst_ni = 1'b1;
    tick(4);

    // R9 reset values
    check("R9 reset fields", dut_vec, model_vec());
    check("R9 reset mutes", {sec_mute, spk_mute, port_a, port_b}, 4'b1100);
    check("R11 sda released after reset", sda_oe, 0);

    // R1 R5 single write with addr_sel low
    sel = 1'b0;
    dbuf[0] = 8'hFF;
    xfer(7'b1000000, 1'b0, 8'h00, 1, 1'b1, acks);
    check("R1 acks sel low", acks, 3);
    check("R5 master volume", vol_main, 6'h3F);

    // R4 R5 burst across 0x01..0x04
    dbuf[0] = 8'hFF; dbuf[1] = 8'h0A; dbuf[2] = 8'h13; dbuf[3] = 8'hF7;
    xfer(7'b1000000, 1'b0, 8'h01, 4, 1'b1, acks);
    check("R4 burst acks", acks, 6);
    check("R5 R4 burst fields", dut_vec, model_vec());
    check("R5 treble low nibble", treble, 4'h7);

    // R8 R6 R7 walk through hole into 0x08 and 0x09
    dbuf[0] = 8'h05; dbuf[1] = 8'hAA; dbuf[2] = 8'hBB; dbuf[3] = 8'hCC;
    dbuf[4] = 8'h95; dbuf[5] = 8'hC7;
    xfer(7'b1000000, 1'b0, 8'h04, 6, 1'b1, acks);
    check("R8 hole acks", acks, 8);
    check("R6 secondary byte", {sec_mute, port_a, port_b, sec_src}, {1'b0, 1'b0, 1'b1, 4'h5});
    check("R7 speaker byte", {fx_hi, spk_mute, fx_lo, stereo, spk_src}, {4'b1100, 4'h7});
    check("R8 R4 hole fields", dut_vec, model_vec());

    // R8 writes above top of map
    dbuf[0] = 8'h00; dbuf[1] = 8'h00;
    xfer(7'b1000000, 1'b0, 8'h0A, 2, 1'b1, acks);
    check("R8 above map acks", acks, 4);
    check("R8 above map no change", dut_vec, model_vec());

    // R2 old address with sel high, then R1 new address
    sel = 1'b1;
    dbuf[0] = 8'h00; dbuf[1] = 8'h00;
    xfer(7'b1000000, 1'b0, 8'h00, 2, 1'b1, acks);
    check("R2 mismatch no ack", acks, 0);
    check("R2 mismatch no change", dut_vec, model_vec());
    dbuf[0] = 8'h3A;
    xfer(7'b1000001, 1'b0, 8'h09, 1, 1'b1, acks);
    check("R1 acks sel high", acks, 3);
    check("R9 R7 speaker unmuted", {spk_mute, fx_lo, stereo, spk_src}, {3'b011, 4'hA});

    // R2 read bit
    dbuf[0] = 8'h00;
    xfer(7'b1000001, 1'b1, 8'h00, 1, 1'b1, acks);
    check("R2 read bit no ack", acks, 0);
    check("R2 read bit no change", dut_vec, model_vec());

    // R10 repeated start
    dbuf[0] = 8'h11;
    xfer(7'b1000001, 1'b0, 8'h03, 1, 1'b0, acks);
    check("R10 first part acks", acks, 3);
    dbuf[0] = 8'h2A;
    xfer(7'b1000001, 1'b0, 8'h00, 1, 1'b1, acks);
    check("R10 second part acks", acks, 3);
    check("R10 fields", {bass, vol_main}, {5'h11, 6'h2A});

    // R9 mute only clears by writing zero, set again by one
    dbuf[0] = 8'h40;
    xfer(7'b1000001, 1'b0, 8'h08, 1, 1'b1, acks);
    check("R9 R6 secondary mute set", sec_mute, 1'b1);

    // random traffic
    for (int t = 0; t < 30; t++) begin
      sel = 1'($urandom % 2);
      case ($urandom % 8)
        0: begin a = 7'b1000010; rd = 1'b0; end
        1: begin a = {6'b100000, sel}; rd = 1'b1; end
        default: begin a = {6'b100000, sel}; rd = 1'b0; end
      endcase
      sub = 8'($urandom % 12);
      n = 1 + int'($urandom % 5);
      for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
      xfer(a, rd, sub, n, 1'b1, acks);
      check("R3 R4 random acks", acks, exp_acks(a, rd, n));
      check("R4 R5 R6 R7 random fields", dut_vec, model_vec());
    end

    check("R11 no pull outside ack", glitch, 0);
    check("R11 sda released at end", sda_oe, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule